// File: doc/BRIEF.md
# Two-Game Cartridge Outer-Block Bank Mapper

This block translates addresses for a cartridge that holds two games side by side. A set of bank registers in the scanline-counter style divides each game's program space into 8 KiB pages and its pattern space into 1 KiB pages. A single outer block bit then chooses which 128 KiB half of the program ROM and of the pattern ROM is visible. The CPU loads every register through a one-cycle write strobe.

CPU addresses in the upper 32 KiB window become an 18-bit program ROM address. PPU pattern addresses (13 bits) become an 18-bit pattern ROM address. Both outputs are combinational from the current register state and the incoming address. The outer bit sits in the 0x6000–0x7FFF window, because the cartridge carries no work RAM. It accepts a write only while the RAM-control register allows RAM writes.

Top module: `obm_mapper`

## Requirements
- R1: After reset, the outer bit, the bank-select register, all bank registers and RAM control are zero. CPU 0xE000 then maps to page 15, 0xC000 to page 14, 0x8000 to page 0, and PPU 0x1000 to pattern page 0.
- R2: A CPU write anywhere in 0x6000–0x7FFF loads data bit 0 into the outer bit when RAM control holds the value 10 in bits 7:6 (enable = bit 7 set, protect = bit 6 clear). Other data bits are discarded.
- R3: A write to 0x6000–0x7FFF has no effect on the outer bit while RAM control bits 7:6 are 00, 01 or 11.
- R4: For 0x8000–0xFFFF, the program ROM address is {outer bit, low 4 bits of the inner page, CPU A12:A0}.
- R5: The pattern ROM address is {outer bit, low 7 bits of the inner page, PPU A9:A0}.
- R6: With program swap (bank-select bit 6) clear, windows 0x8000/0xA000/0xC000/0xE000 use bank register 6, bank register 7, page 14 and page 15. With the swap bit set, 0x8000 and 0xC000 exchange their sources.
- R7: Bank registers 0 and 1 each cover 2 KiB as an even/odd page pair (low bit forced 0 then 1). Registers 2–5 each cover 1 KiB. With pattern invert (bank-select bit 7) clear, the pairs fill 0x0000–0x0FFF and registers 2–5 fill 0x1000–0x1FFF in order. With it set, the two 4 KiB halves trade places.
- R8: For CPU addresses below 0x8000, the program ROM select output is low and the program ROM address is zero.
- R9: Register decode uses A15:A13 and A0. An even address in 0x8000–0x9FFF writes bank select (index in bits 2:0). An odd address there writes the bank register named by the stored index. An odd address in 0xA000–0xBFFF writes RAM control. Writes to even 0xA000–0xBFFF and to 0xC000–0xFFFF change no mapping.
- R10: Both ROM addresses follow an address change within the same cycle. A register write shows in the mapping from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_addr | input | 16 | CPU address for both writes and lookups |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | PPU pattern address |
| prg_rom_addr | output | 18 | Program ROM byte address |
| prg_rom_sel | output | 1 | High when cpu_addr is in 0x8000–0xFFFF |
| chr_rom_addr | output | 18 | Pattern ROM byte address |

## Verification
The properties assume that the CPU address, write data and strobe hold known values on every clock edge after reset. The combinational mapping checks sample the address in every cycle, and the outer-bit load check samples the data bit in every cycle. The bench drives all inputs to defined values from time zero and changes them only on falling edges. Its random writes are drawn from the 0x6000 window, each register slot, the ignored even and upper addresses, and all four RAM-control codes, so that gated and ungated outer-bit writes both occur.

// File: rtl/obm_pkg.sv
package obm_pkg;
  localparam int CPU_AW    = 16;
  localparam int PPU_AW    = 13;
  localparam int DATA_W    = 8;
  localparam int PRG_OFS_W = 13;
  localparam int CHR_OFS_W = 10;
  localparam int PRG_IN_W  = 4;
  localparam int CHR_IN_W  = 7;
  localparam int OUTER_W   = 1;
  localparam int N_PAIR    = 2;
  localparam int N_SINGLE  = 4;
  localparam int N_PRG     = 2;
  localparam int N_BANK    = N_PAIR + N_SINGLE + N_PRG;
  localparam int IDX_W     = $clog2(N_BANK);
  localparam int ROM_AW    = OUTER_W + PRG_IN_W + PRG_OFS_W;

  localparam logic [PRG_IN_W-1:0] PG_LAST   = {PRG_IN_W{1'b1}};
  localparam logic [PRG_IN_W-1:0] PG_SECOND = PG_LAST - 1'b1;

  typedef struct packed {
    logic             chr_inv;
    logic             prg_swap;
    logic [IDX_W-1:0] idx;
  } bsel_t;

  // bit 7 = enable, bit 6 = write protect
  typedef enum logic [1:0] {
    RC_OFF    = 2'b00,
    RC_OFF_WP = 2'b01,
    RC_RW     = 2'b10,
    RC_RO     = 2'b11
  } ramctl_e;

  typedef logic [N_PAIR-1:0][CHR_IN_W-2:0]  pair_t;
  typedef logic [N_SINGLE-1:0][CHR_IN_W-1:0] single_t;
  typedef logic [N_PRG-1:0][PRG_IN_W-1:0]    prgreg_t;

  function automatic logic [PRG_IN_W-1:0] prg_inner(
    input logic       swap,
    input logic [1:0] win,
    input prgreg_t    regs
  );
    logic [PRG_IN_W-1:0] r;
    unique case (win)
      2'd0:    r = swap ? PG_SECOND : regs[0];
      2'd1:    r = regs[1];
      2'd2:    r = swap ? regs[0] : PG_SECOND;
      default: r = PG_LAST;
    endcase
    return r;
  endfunction

  function automatic logic [CHR_IN_W-1:0] chr_inner(
    input logic       inv,
    input logic [2:0] slot,
    input pair_t      pr,
    input single_t    sg
  );
    logic [2:0]          s;
    logic [CHR_IN_W-1:0] r;
    s = {slot[2] ^ inv, slot[1:0]};
    if (!s[2]) r = {pr[s[1]], s[0]};
    else       r = sg[s[1:0]];
    return r;
  endfunction

  function automatic logic [ROM_AW-1:0] join_prg(
    input logic [OUTER_W-1:0]   outer,
    input logic [PRG_IN_W-1:0]  inner,
    input logic [PRG_OFS_W-1:0] ofs
  );
    return {outer, inner, ofs};
  endfunction

  function automatic logic [ROM_AW-1:0] join_chr(
    input logic [OUTER_W-1:0]   outer,
    input logic [CHR_IN_W-1:0]  inner,
    input logic [CHR_OFS_W-1:0] ofs
  );
    return {outer, inner, ofs};
  endfunction
endpackage

// File: rtl/obm_regs.sv
module obm_regs
  import obm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [2:0]         addr_hi,
  input  logic               addr_lsb,
  input  logic [DATA_W-1:0]  wdata,
  output bsel_t              bsel_q,
  output pair_t              pair_q,
  output single_t            single_q,
  output prgreg_t            prg_q,
  output logic [OUTER_W-1:0] outer_q,
  output logic               blk_wr_req,
  output logic               blk_wr_ok
);
  localparam logic [2:0] WIN_RAM  = 3'b011;
  localparam logic [2:0] WIN_SEL  = 3'b100;
  localparam logic [2:0] WIN_CTRL = 3'b101;

  ramctl_e ram_ctl_q;
  logic    sel_hit, data_hit, ctl_hit;

  assign sel_hit    = wr && (addr_hi == WIN_SEL)  && !addr_lsb;
  assign data_hit   = wr && (addr_hi == WIN_SEL)  &&  addr_lsb;
  assign ctl_hit    = wr && (addr_hi == WIN_CTRL) &&  addr_lsb;
  assign blk_wr_req = wr && (addr_hi == WIN_RAM);
  assign blk_wr_ok  = blk_wr_req && (ram_ctl_q == RC_RW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsel_q    <= '0;
      ram_ctl_q <= RC_OFF;
      outer_q   <= '0;
    end else begin
      if (sel_hit) begin
        bsel_q.chr_inv  <= wdata[7];
        bsel_q.prg_swap <= wdata[6];
        bsel_q.idx      <= wdata[IDX_W-1:0];
      end
      if (ctl_hit)   ram_ctl_q <= ramctl_e'(wdata[7:6]);
      if (blk_wr_ok) outer_q   <= wdata[OUTER_W-1:0];
    end
  end

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    logic hit;
    assign hit = data_hit && (bsel_q.idx == IDX_W'(g));
    if (g < N_PAIR) begin : g_pair
      logic [CHR_IN_W-2:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wdata[CHR_IN_W-1:1];
      end
      assign pair_q[g] = q;
    end else if (g < N_PAIR + N_SINGLE) begin : g_single
      logic [CHR_IN_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wdata[CHR_IN_W-1:0];
      end
      assign single_q[g-N_PAIR] = q;
    end else begin : g_prg
      logic [PRG_IN_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wdata[PRG_IN_W-1:0];
      end
      assign prg_q[g-N_PAIR-N_SINGLE] = q;
    end
  end
endmodule

// File: rtl/obm_prg_map.sv
module obm_prg_map
  import obm_pkg::*;
(
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               swap,
  input  prgreg_t            prg_q,
  input  logic [OUTER_W-1:0] outer,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic               rom_sel
);
  logic [PRG_IN_W-1:0] inner;

  assign rom_sel = cpu_addr[CPU_AW-1];
  assign inner   = prg_inner(swap, cpu_addr[CPU_AW-2:CPU_AW-3], prg_q);

  always_comb begin
    if (rom_sel) rom_addr = join_prg(outer, inner, cpu_addr[PRG_OFS_W-1:0]);
    else         rom_addr = '0;
  end
endmodule

// File: rtl/obm_chr_map.sv
module obm_chr_map
  import obm_pkg::*;
(
  input  logic [PPU_AW-1:0]  ppu_addr,
  input  logic               inv,
  input  pair_t              pair_q,
  input  single_t            single_q,
  input  logic [OUTER_W-1:0] outer,
  output logic [ROM_AW-1:0]  rom_addr
);
  logic [CHR_IN_W-1:0] inner;

  assign inner    = chr_inner(inv, ppu_addr[PPU_AW-1:CHR_OFS_W], pair_q, single_q);
  assign rom_addr = join_chr(outer, inner, ppu_addr[CHR_OFS_W-1:0]);
endmodule

// File: rtl/obm_mapper.sv
module obm_mapper
  import obm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic [ROM_AW-1:0] prg_rom_addr,
  output logic              prg_rom_sel,
  output logic [ROM_AW-1:0] chr_rom_addr
);
  bsel_t              bsel_q;
  pair_t              pair_q;
  single_t            single_q;
  prgreg_t            prg_q;
  logic [OUTER_W-1:0] outer_q;
  logic               blk_wr_req;
  logic               blk_wr_ok;

  obm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cpu_wr),
    .addr_hi   (cpu_addr[CPU_AW-1:CPU_AW-3]),
    .addr_lsb  (cpu_addr[0]),
    .wdata     (cpu_wdata),
    .bsel_q    (bsel_q),
    .pair_q    (pair_q),
    .single_q  (single_q),
    .prg_q     (prg_q),
    .outer_q   (outer_q),
    .blk_wr_req(blk_wr_req),
    .blk_wr_ok (blk_wr_ok)
  );

  obm_prg_map u_prg (
    .cpu_addr(cpu_addr),
    .swap    (bsel_q.prg_swap),
    .prg_q   (prg_q),
    .outer   (outer_q),
    .rom_addr(prg_rom_addr),
    .rom_sel (prg_rom_sel)
  );

  obm_chr_map u_chr (
    .ppu_addr(ppu_addr),
    .inv     (bsel_q.chr_inv),
    .pair_q  (pair_q),
    .single_q(single_q),
    .outer   (outer_q),
    .rom_addr(chr_rom_addr)
  );
endmodule

// File: rtl/obm_checks.sv
module obm_checks
  import obm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              wdata0,
  input logic [ROM_AW-1:0] prg_rom_addr,
  input logic              prg_rom_sel,
  input logic [ROM_AW-1:0] chr_rom_addr,
  input logic              block_q,
  input logic              blk_wr_req,
  input logic              blk_wr_ok
);
  p_blk_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr_ok |=> block_q == $past(wdata0));

  p_blk_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_wr_req && !blk_wr_ok) |=> $stable(block_q));

  p_prg_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[CPU_AW-1] |-> (prg_rom_addr[ROM_AW-1] == block_q &&
                            prg_rom_addr[PRG_OFS_W-1:0] == cpu_addr[PRG_OFS_W-1:0]));

  p_chr_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chr_rom_addr[ROM_AW-1] == block_q);

  p_last_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[CPU_AW-1:CPU_AW-3] == 3'b111) |->
      prg_rom_addr[ROM_AW-2:PRG_OFS_W] == PG_LAST);

  p_low_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[CPU_AW-1] |-> (prg_rom_addr == '0 && !prg_rom_sel));
endmodule

bind obm_mapper obm_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .wdata0      (cpu_wdata[0]),
  .prg_rom_addr(prg_rom_addr),
  .prg_rom_sel (prg_rom_sel),
  .chr_rom_addr(chr_rom_addr),
  .block_q     (outer_q),
  .blk_wr_req  (blk_wr_req),
  .blk_wr_ok   (blk_wr_ok)
);

// File: tb/sim_obm_mapper.sv
module sim_obm_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [12:0] ppu_addr = 13'h0000;
  logic [17:0] prg_rom_addr;
  logic        prg_rom_sel;
  logic [17:0] chr_rom_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // bench model of the programmable state
  logic [7:0] m_sel = 8'h00;
  logic [7:0] m_r [8];
  logic [1:0] m_ctl = 2'b00;
  logic       m_blk = 1'b0;

  obm_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
    .prg_rom_sel(prg_rom_sel), .chr_rom_addr(chr_rom_addr)
  );

  always #2 clk = ~clk;

  function automatic logic [17:0] want_prg(input logic [15:0] a);
    logic [3:0] pg;
    if (!a[15]) return 18'h0;
    case (a[14:13])
      2'd0: pg = m_sel[6] ? 4'd14 : m_r[6][3:0];
      2'd1: pg = m_r[7][3:0];
      2'd2: pg = m_sel[6] ? m_r[6][3:0] : 4'd14;
      default: pg = 4'd15;
    endcase
    return {m_blk, pg, a[12:0]};
  endfunction

  function automatic logic [17:0] want_chr(input logic [12:0] p);
    logic [2:0] s;
    logic [6:0] pg;
    s = {p[12] ^ m_sel[7], p[11:10]};
    case (s)
      3'd0: pg = m_r[0][6:0] & 7'h7E;
      3'd1: pg = m_r[0][6:0] | 7'h01;
      3'd2: pg = m_r[1][6:0] & 7'h7E;
      3'd3: pg = m_r[1][6:0] | 7'h01;
      3'd4: pg = m_r[2][6:0];
      3'd5: pg = m_r[3][6:0];
      3'd6: pg = m_r[4][6:0];
      default: pg = m_r[5][6:0];
    endcase
    return {m_blk, pg, p[9:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a[15]) begin
      case ({a[14:13], a[0]})
        3'b000: m_sel = d;
        3'b001: m_r[m_sel[2:0]] = d;
        3'b011: m_ctl = d[7:6];
        default: ;
      endcase
    end else if (a[15:13] == 3'b011 && m_ctl == 2'b10) begin
      m_blk = d[0];
    end
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic [12:0] p);
    @(negedge clk);
    cpu_addr = a; ppu_addr = p;
    #1;
    chk(req, 32'(prg_rom_addr), 32'(want_prg(a)));
    chk(req, 32'(prg_rom_sel), 32'(a[15]));
    chk(req, 32'(chr_rom_addr), 32'(want_chr(p)));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) m_r[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    probe("R1", 16'hE000, 13'h1000);
    chk("R1", 32'(prg_rom_addr), 32'h1E000);
    probe("R1", 16'hC123, 13'h0000);
    chk("R1", 32'(prg_rom_addr), 32'h1C123);
    probe("R1", 16'h8000, 13'h1FFF);
    chk("R1", 32'(prg_rom_addr), 32'h00000);
    chk("R1", 32'(prg_rom_sel), 32'h1);

    // R8 low addresses
    probe("R8", 16'h6000, 13'h0400);
    chk("R8", 32'(prg_rom_addr), 32'h0);
    probe("R8", 16'h1234, 13'h0800);
    chk("R8", 32'(prg_rom_sel), 32'h0);

    // R3 gated outer writes
    cpu_write(16'hA001, 8'h00); cpu_write(16'h6000, 8'h01);
    probe("R3", 16'hE000, 13'h0000);
    chk("R3", 32'(prg_rom_addr), 32'h1E000);
    cpu_write(16'hA001, 8'hC0); cpu_write(16'h7FFF, 8'h01);
    probe("R3", 16'hE000, 13'h0000);
    chk("R3", 32'(prg_rom_addr), 32'h1E000);
    cpu_write(16'hA001, 8'h40); cpu_write(16'h6000, 8'h01);
    probe("R3", 16'hE000, 13'h0000);
    chk("R3", 32'(prg_rom_addr), 32'h1E000);

    // R2 accepted outer writes, only bit 0 kept
    cpu_write(16'hA001, 8'h80); cpu_write(16'h7ABC, 8'hFF);
    probe("R2", 16'hE000, 13'h0000);
    chk("R2", 32'(prg_rom_addr), 32'h3E000);
    cpu_write(16'h6001, 8'hFE);
    probe("R2", 16'hE000, 13'h0000);
    chk("R2", 32'(prg_rom_addr), 32'h1E000);

    // R9 R4 R6 program banking in both halves
    cpu_write(16'h8000, 8'h06); cpu_write(16'h8001, 8'h03);
    probe("R4", 16'h8000, 13'h0000);
    chk("R4", 32'(prg_rom_addr), 32'h06000);
    cpu_write(16'h6000, 8'h01);
    probe("R4", 16'h8000, 13'h0000);
    chk("R4", 32'(prg_rom_addr), 32'h26000);
    cpu_write(16'h8000, 8'h46);
    probe("R6", 16'h8000, 13'h0000);
    chk("R6", 32'(prg_rom_addr), 32'h3C000);
    probe("R6", 16'hC000, 13'h0000);
    chk("R6", 32'(prg_rom_addr), 32'h26000);

    // R5 R7 pattern banking and invert
    cpu_write(16'h6000, 8'h00);
    cpu_write(16'h8000, 8'h02); cpu_write(16'h8001, 8'h05);
    probe("R5", 16'h8000, 13'h1000);
    chk("R5", 32'(chr_rom_addr), 32'h01400);
    cpu_write(16'h6000, 8'h01);
    probe("R5", 16'h8000, 13'h1000);
    chk("R5", 32'(chr_rom_addr), 32'h21400);
    cpu_write(16'h8000, 8'h80); cpu_write(16'h8001, 8'h0A);
    probe("R7", 16'h8000, 13'h1400);
    chk("R7", 32'(chr_rom_addr), 32'h22C00);
    probe("R7", 16'h8000, 13'h0000);
    chk("R7", 32'(chr_rom_addr), 32'h21400);

    // R9 ignored addresses, R10 same-cycle follow
    cpu_write(16'hA000, 8'h00); cpu_write(16'hC000, 8'h07); cpu_write(16'hE001, 8'h55);
    for (int w = 0; w < 8; w++) probe("R9", 16'(16'h8000 + w * 16'h1000), 13'(w * 13'h0400));
    cpu_write(16'h6000, 8'h00);
    probe("R10", 16'hE000, 13'h0000);
    chk("R10", 32'(prg_rom_addr), 32'h1E000);

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [31:0] r;
      logic [15:0] a;
      logic [7:0]  d;
      r = $urandom;
      d = 8'(r[31:24]);
      case (r[2:0])
        3'd0:    a = {3'b011, r[15:3]};
        3'd1:    a = {3'b100, r[15:4], 1'b0};
        3'd2:    a = {3'b100, r[15:4], 1'b1};
        3'd3:    begin a = {3'b101, r[15:4], 1'b1}; d = {r[5:4], d[5:0]}; end
        3'd4:    a = {3'b101, r[15:4], 1'b0};
        3'd5:    a = {2'b11, r[16:3]};
        default: a = {3'b011, r[15:3]};
      endcase
      cpu_write(a, d);
      probe("R4", 16'($urandom), 13'($urandom));
      probe("R5", 16'($urandom), 13'($urandom));
    end

    finish_run();
  end
endmodule